// File: doc/BRIEF.md
# Six-Channel DMA Burst Arbiter

This block decides which of six DMA channels may move its next burst. Each channel raises a request line while it has work pending. The arbiter answers with a registered one-hot grant. It holds that grant until the granted channel pulses the burst-done strobe. Channel numbers run from 1 to 6 and map to request and grant bits 0 to 5.

By default every channel has the same weight. At each burst boundary the arbiter searches for the next requester starting at the channel after the last one it served. A mode input lets channel 1 win every boundary at which it is requesting, so it can take over from a channel between two of that channel's bursts. While channel 1 holds the bus after such a takeover, a shadow code names the channel it displaced. When channel 1 stops requesting, that channel gets the next turn if it still wants one.

A restart strobe returns the rotation to its starting point and drops any remembered displaced channel. It never cuts short a burst that is already running.

Top module: `dma_prio_arb`

## Requirements
- R1: `grant` is one-hot or all zero. It becomes zero at a burst boundary at which no channel requests.
- R2: A burst boundary is a cycle in which `grant` is zero or `burst_done` is high. A nonzero `grant` stays unchanged until `burst_done` is seen. The new grant appears on the clock edge that samples the boundary.
- R3: With `ch1_first` low, the next grant goes to the first requesting channel found after the last granted channel, in ascending order, wrapping from channel 6 to channel 1.
- R4: With `ch1_first` high, channel 1 is granted at every boundary at which `req[0]` is high.
- R5: When channel 1 takes over at the end of a burst of channel k (k from 2 to 6), `shadow_code` becomes k. When channel 1 takes over from idle, `shadow_code` is 0. `shadow_code` never holds 1, and it keeps its value across further channel-1 bursts.
- R6: When `shadow_code` is k and channel 1 is not requesting at a boundary, channel k is granted if `req[k-1]` is high. Otherwise the rotation of R3 applies. In both cases `shadow_code` returns to 0.
- R7: `active_code` is 0 when `grant` is zero, and n when grant bit n-1 is set.
- R8: A high `prio_restart` makes the next search start at channel 1, as if channel 6 were the last one served, and clears `shadow_code`. It leaves a running burst granted.
- R9: After reset, `grant`, `active_code` and `shadow_code` are all zero, and the first search starts at channel 1.
- R10: With `ch1_first` low, channel 1 takes its turn in the rotation like any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCH | Per-channel request, bit 0 is channel 1 |
| burst_done | input | 1 | Granted channel finishes its burst this cycle |
| ch1_first | input | 1 | Channel 1 takes precedence at boundaries |
| prio_restart | input | 1 | Write-one strobe that restarts the rotation |
| grant | output | NCH | One-hot grant, bit 0 is channel 1 |
| active_code | output | CW | Granted channel number, 0 when none |
| shadow_code | output | CW | Channel displaced by channel 1, 0 when none |

## Verification
A wrong last-served pointer does not change the current grant. It shows one boundary later, as the wrong channel in `active_code` when several channels request at once. For that reason the bench runs a long rotation with all channels requesting. A lost or stale shadow code shows at the first boundary after channel 1 drops its request, as the wrong channel granted or a nonzero `shadow_code`. A grant that moves mid-burst shows on the very next clock edge.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 6,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           burst_done,
  input  logic           ch1_first,
  input  logic           prio_restart,
  output logic [NCH-1:0] grant,
  output logic [CW-1:0]  active_code,
  output logic [CW-1:0]  shadow_code
);

  logic [NCH-1:0] grant_q, nxt, rr_pick;
  logic [CW-1:0]  last_q, shadow_q, nxt_sh, cur_code, nxt_code, last_eff, shadow_eff;
  logic           boundary, found;

  assign boundary   = (grant_q == '0) || burst_done;
  assign last_eff   = prio_restart ? CW'(NCH - 1) : last_q;
  assign shadow_eff = prio_restart ? '0 : shadow_q;

  always_comb begin
    rr_pick = '0;
    found   = 1'b0;
    for (int o = 1; o <= NCH; o++) begin
      if (!found && req[(int'(last_eff) + o) % NCH]) begin
        found = 1'b1;
        rr_pick[(int'(last_eff) + o) % NCH] = 1'b1;
      end
    end
  end

  always_comb begin
    cur_code = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) cur_code = CW'(i + 1);
  end

  always_comb begin
    if (ch1_first && req[0]) begin
      nxt    = NCH'(1);
      nxt_sh = grant_q[0] ? shadow_eff : cur_code;
    end else if (shadow_eff != '0 && req[shadow_eff - 1'b1]) begin
      nxt    = NCH'(1) << (shadow_eff - 1'b1);
      nxt_sh = '0;
    end else begin
      nxt    = rr_pick;
      nxt_sh = '0;
    end
  end

  always_comb begin
    nxt_code = '0;
    for (int i = 0; i < NCH; i++)
      if (nxt[i]) nxt_code = CW'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      last_q   <= CW'(NCH - 1);
      shadow_q <= '0;
    end else begin
      if (boundary) begin
        grant_q  <= nxt;
        shadow_q <= nxt_sh;
      end else if (prio_restart) begin
        shadow_q <= '0;
      end
      if (boundary && nxt_code != '0) last_q <= nxt_code - 1'b1;
      else if (prio_restart)          last_q <= CW'(NCH - 1);
    end
  end

  assign grant       = grant_q;
  assign active_code = cur_code;
  assign shadow_code = shadow_q;

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_hold_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !burst_done) |=> $stable(grant));

  p_ch1_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_first && req[0] && boundary) |=> grant[0]);

  p_shadow_not_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_code != CW'(1));

  p_shadow_under_ch1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_code != '0) |-> grant[0]);

  p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_code != '0 && boundary && !(ch1_first && req[0]) && !prio_restart
     && req[shadow_code - 1'b1]) |=> (active_code == $past(shadow_code)));

  p_grant_to_requester_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && req == '0) |=> (grant == '0));

endmodule

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] req = '0;
  logic burst_done = 0, ch1_first = 0, prio_restart = 0;
  logic [NCH-1:0] grant;
  logic [CW-1:0] active_code, shadow_code;
  int errors = 0, checks = 0;
  bit done_flag = 0;

  dma_prio_arb #(.NCH(NCH)) dut (.clk(clk), .rst_n(rst_n), .req(req), .burst_done(burst_done),
    .ch1_first(ch1_first), .prio_restart(prio_restart), .grant(grant),
    .active_code(active_code), .shadow_code(shadow_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_st(string tag, int code, int sh);
    logic [NCH-1:0] eg;
    eg = (code == 0) ? '0 : (NCH'(1) << (code - 1));
    checks++;
    if (grant !== eg || active_code !== CW'(code) || shadow_code !== CW'(sh)) begin
      errors++;
      $display("FAIL %s: grant=%b code=%0d shadow=%0d expected grant=%b code=%0d shadow=%0d",
               tag, grant, active_code, shadow_code, eg, code, sh);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req = '0; burst_done = 0; ch1_first = 0; prio_restart = 0;
    tick(); rst_n = 1; @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    expect_st("R9 reset state", 0, 0);
    tick();
    expect_st("R1 idle with no request", 0, 0);
  endtask

  task automatic t_rotate_all();
    do_reset();
    req = 6'b111111;
    tick();
    expect_st("R9 first grant channel 1", 1, 0);
    burst_done = 1;
    for (int n = 0; n < 13; n++) begin
      tick();
      expect_st("R3 rotation all requesting", ((n + 1) % NCH) + 1, 0);
    end
    burst_done = 0;
  endtask

  task automatic t_sparse();
    do_reset();
    req = 6'b101010;
    tick();
    expect_st("R3 sparse first ch2", 2, 0);
    req = 6'b101011; burst_done = 0;
    tick(); tick();
    expect_st("R2 held without burst_done", 2, 0);
    burst_done = 1; tick();
    expect_st("R3 sparse next ch4", 4, 0);
    tick();
    expect_st("R3 sparse next ch6", 6, 0);
    tick();
    expect_st("R3 R10 wrap to ch1", 1, 0);
    tick();
    expect_st("R10 ch1 no precedence", 2, 0);
    req = '0; tick();
    expect_st("R1 zero when none requests", 0, 0);
    burst_done = 0;
    req = 6'b000011; tick();
    expect_st("R7 code after idle", 1, 0);
  endtask

  task automatic t_preempt();
    do_reset();
    ch1_first = 1;
    req = 6'b000100; tick();
    expect_st("R3 ch3 granted", 3, 0);
    req = 6'b000101; tick();
    expect_st("R2 no preempt mid burst", 3, 0);
    burst_done = 1; tick();
    expect_st("R4 R5 ch1 takes over from ch3", 1, 3);
    tick();
    expect_st("R5 shadow kept over ch1 bursts", 1, 3);
    req = 6'b000110; tick();
    expect_st("R6 return to ch3 not ch2", 3, 0);
    req = '0; tick();
    expect_st("R1 idle after return", 0, 0);
    burst_done = 0;
    req = 6'b000001; tick();
    expect_st("R5 takeover from idle", 1, 0);
  endtask

  task automatic t_return_dropped();
    do_reset();
    ch1_first = 1;
    req = 6'b000110; tick();
    expect_st("R3 ch2 granted", 2, 0);
    req = 6'b000111; burst_done = 1; tick();
    expect_st("R5 shadow ch2", 1, 2);
    req = 6'b000100; tick();
    expect_st("R6 rotate when shadow drops", 3, 0);
    burst_done = 0;
  endtask

  task automatic t_restart();
    do_reset();
    req = 6'b111111;
    tick(); burst_done = 1; tick(); tick();
    burst_done = 0;
    expect_st("R3 reach ch3", 3, 0);
    prio_restart = 1; tick(); prio_restart = 0;
    expect_st("R8 running burst kept", 3, 0);
    burst_done = 1; tick();
    expect_st("R8 search restarts at ch1", 1, 0);
    tick();
    expect_st("R8 rotation continues", 2, 0);
    prio_restart = 1; tick(); prio_restart = 0;
    expect_st("R8 restart with boundary", 1, 0);
    ch1_first = 1; req = 6'b010001; burst_done = 0; tick();
    burst_done = 1; req = 6'b010000; tick();
    expect_st("R8 setup ch5", 5, 0);
    req = 6'b010001; tick();
    expect_st("R5 takeover from ch5", 1, 5);
    burst_done = 0; prio_restart = 1; tick(); prio_restart = 0;
    expect_st("R8 shadow cleared", 1, 0);
    req = 6'b010000; burst_done = 1; tick();
    expect_st("R8 R6 no return after restart", 5, 0);
    burst_done = 0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_rotate_all();
    t_sparse();
    t_preempt();
    t_return_dropped();
    t_restart();
    finish_up();
  end
endmodule